// File: doc/BRIEF.md
# Predicated Integer ALU with Condition Flags

This block is a 32-bit execution stage for register-to-register data operations. It takes a first operand, a second operand that has already been through an external shifter (with that shifter's carry-out), a 4-bit operation code, a 4-bit condition code and a set-flags bit. It keeps its own four condition flags: negative, zero, carry and overflow. Each issued operation runs only when its condition code holds against the flags as they stand at issue time. An operation whose condition fails does nothing.

Moves, bitwise logic, add and subtract (including carry-in, borrow and reversed-operand forms) produce a result and raise a destination write-enable. Four test operations only update the flags. The other operations change the flags only when the set-flags bit is high. Results and flags register one clock after the valid strobe. A following operation therefore sees the flags left by the last operation that actually executed, which lets conditional compares be chained.

Top module: `pred_alu`

## Requirements
- R1: Opcodes 0xD (copy), 0xF (invert), 0x0 (AND), 0xC (OR), 0x1 (XOR) and 0xE (a AND NOT b) produce, respectively, b, ~b, a&b, a|b, a^b and a&~b on `result_o`.
- R2: Opcodes 0x4 (a+b), 0x5 (a+b+C), 0x2 (a-b), 0x6 (a-b-NOT C), 0x3 (b-a) and 0x7 (b-a-NOT C) produce the 32-bit arithmetic result, where C is the carry flag at issue time.
- R3: Opcodes 0xA (a-b), 0xB (a+b), 0x8 (a&b) and 0x9 (a^b) never raise `wr_en_o`. When their condition holds they update the flags whatever the set-flags bit is.
- R4: Every opcode other than the four tests leaves all four flags unchanged when `setf_i` is low. For example, a copy of zero without set-flags keeps Z as it was.
- R5: When flags update, N is bit 31 of the computed value and Z is set exactly when all 32 bits of that value are zero.
- R6: For arithmetic opcodes with flag update, C is the carry out of the addition, and for subtract forms C is 1 when no borrow occurs. V is set on signed two's-complement overflow.
- R7: For logical and move opcodes with flag update, C takes `shift_c_i` and V keeps its previous value.
- R8: Condition codes (in `flags_o` bit order N=3, Z=2, C=1, V=0) are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 0xA N==V, 0xB N!=V, 0xC !Z&(N==V), 0xD Z|(N!=V), 0xE always.
- R9: When the condition fails, `wr_en_o` stays low, and `flags_o` and `result_o` keep their values.
- R10: Condition code 0xF never executes.
- R11: `result_o`, `wr_en_o` and `flags_o` reflect an operation on the clock edge at which it is issued with `valid_i`. Back-to-back operations see the flags written by the preceding executed operation.
- R12: Under reset, `flags_o`, `result_o` and `wr_en_o` are all zero.
- R13: A cycle with `valid_i` low drives `wr_en_o` low and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation issue strobe |
| opcode_i | input | 4 | Operation code |
| cond_i | input | 4 | Condition code |
| setf_i | input | 1 | Set-flags request |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second (shifted) operand |
| shift_c_i | input | 1 | Carry-out of the external shifter |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Destination write-enable, one cycle per executed writing operation |
| flags_o | output | 4 | Flags {N,Z,C,V} |

## Verification
The bench targets signed overflow at the 0x7FFFFFFF/0x80000000 boundary and the carry-as-not-borrow sense of the subtract forms. A design that inverts the borrow would make both the carry-in subtracts and the unsigned conditions come out wrong. It chains a compare, a compare-if-not-equal and a move-if-equal, which exposes a design that reads stale flags or lets a skipped compare update them. It also drives zero results without set-flags, where a design that always updates Z would differ, and it uses code 0xF, where a design that decodes that code as "always" would write. Random operands biased toward 0, all-ones and the sign-boundary values sweep all sixteen condition codes against the flag states that the bench's own model produces.

// File: rtl/pred_alu_pkg.sv
package pred_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Test-class operations: flags only, no destination write.
  function automatic logic op_is_test(input logic [3:0] op);
    return (op[3:2] == 2'b10);
  endfunction

  // Operations whose flags come from the adder.
  function automatic logic op_is_arith(input logic [3:0] op);
    return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC,
                       OP_CMP, OP_CMN});
  endfunction

endpackage

// File: rtl/pred_alu_cond.sv
module pred_alu_cond
  import pred_alu_pkg::*;
(
  input  logic [3:0] cond,
  input  nzcv_t      flags,
  output logic       met
);
  always_comb begin
    unique case (cond_e'(cond))
      CC_EQ: met = flags.z;
      CC_NE: met = !flags.z;
      CC_CS: met = flags.c;
      CC_CC: met = !flags.c;
      CC_MI: met = flags.n;
      CC_PL: met = !flags.n;
      CC_VS: met = flags.v;
      CC_VC: met = !flags.v;
      CC_HI: met = flags.c && !flags.z;
      CC_LS: met = !flags.c || flags.z;
      CC_GE: met = (flags.n == flags.v);
      CC_LT: met = (flags.n != flags.v);
      CC_GT: met = !flags.z && (flags.n == flags.v);
      CC_LE: met = flags.z || (flags.n != flags.v);
      CC_AL: met = 1'b1;
      default: met = 1'b0;
    endcase
  end
endmodule

// File: rtl/pred_alu_core.sv
module pred_alu_core
  import pred_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             shift_c,
  input  nzcv_t            flags_in,
  output logic [WIDTH-1:0] value,
  output nzcv_t            flags_out
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] add_x, add_y;
  logic             add_cin;
  logic [WIDTH:0]   add_sum;
  logic [WIDTH-1:0] logic_val;
  logic             arith;

  // Adder operand steering: subtraction is x + ~y + carry-in.
  always_comb begin
    add_x   = a;
    add_y   = b;
    add_cin = 1'b0;
    unique case (alu_op_e'(op))
      OP_ADC:         add_cin = flags_in.c;
      OP_SUB, OP_CMP: begin add_y = ~b; add_cin = 1'b1;       end
      OP_SBC:         begin add_y = ~b; add_cin = flags_in.c; end
      OP_RSB:         begin add_x = b; add_y = ~a; add_cin = 1'b1;       end
      OP_RSC:         begin add_x = b; add_y = ~a; add_cin = flags_in.c; end
      default: ;
    endcase
  end

  assign add_sum = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_cin};

  always_comb begin
    unique case (alu_op_e'(op))
      OP_AND, OP_TST: logic_val = a & b;
      OP_EOR, OP_TEQ: logic_val = a ^ b;
      OP_ORR:         logic_val = a | b;
      OP_BIC:         logic_val = a & ~b;
      OP_MVN:         logic_val = ~b;
      default:        logic_val = b;
    endcase
  end

  assign arith = op_is_arith(op);
  assign value = arith ? add_sum[MSB:0] : logic_val;

  always_comb begin
    flags_out.n = value[MSB];
    flags_out.z = (value == '0);
    if (arith) begin
      flags_out.c = add_sum[WIDTH];
      flags_out.v = (add_x[MSB] == add_y[MSB]) && (add_sum[MSB] != add_x[MSB]);
    end else begin
      flags_out.c = shift_c;
      flags_out.v = flags_in.v;
    end
  end
endmodule

// File: rtl/pred_alu.sv
module pred_alu
  import pred_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [3:0]       opcode_i,
  input  logic [3:0]       cond_i,
  input  logic             setf_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic             shift_c_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o
);
  nzcv_t            flags_q;
  nzcv_t            flags_nxt;
  logic [WIDTH-1:0] value;
  logic             cond_met;
  logic             exec_fire;
  logic             flag_upd;
  logic             dest_wr;

  pred_alu_cond u_cond (
    .cond  (cond_i),
    .flags (flags_q),
    .met   (cond_met)
  );

  pred_alu_core #(.WIDTH(WIDTH)) u_core (
    .op        (opcode_i),
    .a         (op_a_i),
    .b         (op_b_i),
    .shift_c   (shift_c_i),
    .flags_in  (flags_q),
    .value     (value),
    .flags_out (flags_nxt)
  );

  assign exec_fire = valid_i && cond_met;
  assign flag_upd  = exec_fire && (setf_i || op_is_test(opcode_i));
  assign dest_wr   = exec_fire && !op_is_test(opcode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= '0;
      result_o <= '0;
      wr_en_o  <= 1'b0;
    end else begin
      wr_en_o <= dest_wr;
      if (dest_wr)  result_o <= value;
      if (flag_upd) flags_q  <= flags_nxt;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/pred_alu_chk.sv
module pred_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_i,
  input logic [3:0]  opcode_i,
  input logic [3:0]  cond_i,
  input logic        setf_i,
  input logic [31:0] result_o,
  input logic        wr_en_o,
  input logic [3:0]  flags_o,
  input logic        cond_met
);
  logic is_test, is_arith;
  assign is_test  = pred_alu_pkg::op_is_test(opcode_i);
  assign is_arith = pred_alu_pkg::op_is_arith(opcode_i);

  assert_test_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && cond_met && is_test |=> !wr_en_o);

  assert_no_setf_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !is_test && !setf_i |=> $stable(flags_o));

  assert_nz_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && cond_met && !is_test && setf_i |=>
      (flags_o[3] == result_o[31]) && (flags_o[2] == (result_o == 32'd0)));

  assert_logic_v_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !is_arith |=> $stable(flags_o[0]));

  assert_fail_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !cond_met |=> !wr_en_o && $stable(flags_o) && $stable(result_o));

  assert_never_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (cond_i == 4'hF) |=> !wr_en_o);

  assert_write_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && cond_met && !is_test |=> wr_en_o);

  assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !wr_en_o && $stable(flags_o));
endmodule

bind pred_alu pred_alu_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid_i  (valid_i),
  .opcode_i (opcode_i),
  .cond_i   (cond_i),
  .setf_i   (setf_i),
  .result_o (result_o),
  .wr_en_o  (wr_en_o),
  .flags_o  (flags_o),
  .cond_met (cond_met)
);

// File: tb/tb_pred_alu.sv
`timescale 1ns/1ps
module tb_pred_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  opcode_i = '0;
  logic [3:0]  cond_i = '0;
  logic        setf_i = 1'b0;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic        shift_c_i = 1'b0;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int fails  = 0;
  logic [3:0]  m_flags = '0;
  logic [31:0] m_res = '0;

  always #2 clk = ~clk;

  pred_alu dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
    .cond_i(cond_i), .setf_i(setf_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .shift_c_i(shift_c_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .flags_o(flags_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // Even codes test a flag predicate, odd codes its negation.
  function automatic bit m_cond(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cy, v, base;
    {n, z, cy, v} = f;
    if (c == 4'hE) return 1'b1;
    if (c == 4'hF) return 1'b0;
    case (c[3:1])
      3'd0: base = z;
      3'd1: base = cy;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = cy & ~z;
      3'd5: base = ~(n ^ v);
      default: base = ~z & ~(n ^ v);
    endcase
    return base ^ c[0];
  endfunction

  task automatic m_add(input logic [31:0] x, y, input bit ci,
                       output logic [31:0] r, output bit c, output bit v);
    longint s;
    longint unsigned u;
    u = longint'({1'b0, x}) + longint'({1'b0, y}) + ci;
    s = longint'($signed(x)) + longint'($signed(y)) + ci;
    r = u[31:0];
    c = u[32];
    v = (s > 64'sh7FFFFFFF) || (s < -64'sh80000000);
  endtask

  task automatic m_sub(input logic [31:0] x, y, input bit bi,
                       output logic [31:0] r, output bit c, output bit v);
    longint s, d;
    d = longint'({1'b0, x}) - longint'({1'b0, y}) - bi;
    s = longint'($signed(x)) - longint'($signed(y)) - bi;
    r = d[31:0];
    c = (d >= 0);
    v = (s > 64'sh7FFFFFFF) || (s < -64'sh80000000);
  endtask

  function automatic bit m_arith(input logic [3:0] op);
    return (op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB});
  endfunction

  task automatic m_exec(input logic [3:0] op, input logic [31:0] a, b,
                        input bit sc, input logic [3:0] f,
                        output logic [31:0] r, output logic [3:0] nf);
    bit c, v;
    c = sc; v = f[0];
    case (op)
      4'h0, 4'h8: r = a & b;
      4'h1, 4'h9: r = a ^ b;
      4'hC: r = a | b;
      4'hD: r = b;
      4'hE: r = a & ~b;
      4'hF: r = ~b;
      4'h4, 4'hB: m_add(a, b, 1'b0, r, c, v);
      4'h5: m_add(a, b, f[1], r, c, v);
      4'h2, 4'hA: m_sub(a, b, 1'b0, r, c, v);
      4'h6: m_sub(a, b, ~f[1], r, c, v);
      4'h3: m_sub(b, a, 1'b0, r, c, v);
      default: m_sub(b, a, ~f[1], r, c, v);
    endcase
    nf = {r[31], r == 32'd0, c, v};
  endtask

  // Issue one operation at a falling edge; check at the next falling edge.
  task automatic issue(input bit vld, input logic [3:0] op, input logic [3:0] cc,
                       input bit s, input logic [31:0] a, b, input bit sc);
    logic [31:0] r;
    logic [3:0]  nf;
    bit ex, test, w;
    string wt, rt, ft;
    test = (op[3:2] == 2'b10);
    ex   = vld && m_cond(cc, m_flags);
    w    = ex && !test;
    m_exec(op, a, b, sc, m_flags, r, nf);
    wt = (cc == 4'hF) ? "R10" : (!vld ? "R13" : (test ? "R3" : "R8"));
    rt = w ? (m_arith(op) ? "R2" : "R1") : "R9";
    ft = !vld ? "R13" : (!ex ? "R9" : (test ? "R3" : (!s ? "R4" :
         (m_arith(op) ? "R6" : "R7"))));
    if (w) m_res = r;
    if (ex && (s || test)) m_flags = nf;
    valid_i = vld; opcode_i = op; cond_i = cc; setf_i = s;
    op_a_i = a; op_b_i = b; shift_c_i = sc;
    @(negedge clk);
    valid_i = 1'b0;
    chk(wr_en_o == w, wt, "wr_en", {31'd0, wr_en_o}, {31'd0, w});
    chk(result_o == m_res, rt, "result", result_o, m_res);
    chk(flags_o == m_flags, ft, "flags", {28'd0, flags_o}, {28'd0, m_flags});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h0;
      1: return 32'hFFFFFFFF;
      2: return 32'h80000000;
      3: return 32'h7FFFFFFF;
      4: return $urandom_range(0, 4);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(flags_o == 4'h0 && result_o == 32'h0 && wr_en_o == 1'b0, "R12", "reset",
        {27'd0, wr_en_o, flags_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Copy with set-flags, then copy of zero without set-flags (R4)
    issue(1, 4'hD, 4'hE, 1, 32'h0, 32'h1, 1'b1);
    issue(1, 4'hD, 4'hE, 0, 32'h0, 32'h0, 1'b0);
    chk(flags_o[2] == 1'b0, "R4", "Z kept", {31'd0, flags_o[2]}, 32'd0);
    // -3 + 3 with set-flags: zero, carry out (R5, R6)
    issue(1, 4'h4, 4'hE, 1, 32'hFFFFFFFD, 32'h3, 1'b0);
    chk(flags_o == 4'b0110, "R5", "Z on zero sum", {28'd0, flags_o}, 32'h6);
    // Signed overflow both ways (R6)
    issue(1, 4'h4, 4'hE, 1, 32'h7FFFFFFF, 32'h1, 1'b0);
    chk(flags_o == 4'b1001, "R6", "add overflow", {28'd0, flags_o}, 32'h9);
    issue(1, 4'h2, 4'hE, 1, 32'h80000000, 32'h1, 1'b0);
    chk(flags_o == 4'b0011, "R6", "sub overflow", {28'd0, flags_o}, 32'h3);
    // Borrow: 1 - 2 clears C; then SBC uses NOT C
    issue(1, 4'hA, 4'hE, 0, 32'h1, 32'h2, 1'b0);
    issue(1, 4'h6, 4'hE, 1, 32'h10, 32'h3, 1'b0);
    chk(result_o == 32'hC, "R2", "sbc with borrow", result_o, 32'hC);
    issue(1, 4'h7, 4'hE, 1, 32'h3, 32'h10, 1'b0);
    // Logical with set-flags keeps V, C from shifter (R7)
    issue(1, 4'h4, 4'hE, 1, 32'h7FFFFFFF, 32'h1, 1'b0);
    issue(1, 4'hE, 4'hE, 1, 32'hFF, 32'h0F, 1'b1);
    chk(flags_o[1:0] == 2'b11, "R7", "C from shifter, V kept",
        {30'd0, flags_o[1:0]}, 32'h3);

    // Chained compares (R11): x==4 || x==10 -> write 0
    for (int k = 0; k < 3; k++) begin
      logic [31:0] x;
      x = (k == 0) ? 32'd4 : ((k == 1) ? 32'd10 : 32'd7);
      issue(1, 4'hD, 4'hE, 0, 32'h0, 32'h55, 1'b0);
      issue(1, 4'hA, 4'hE, 0, x, 32'd4, 1'b0);
      issue(1, 4'hA, 4'h1, 0, x, 32'd10, 1'b0);
      issue(1, 4'hD, 4'h0, 0, 32'h0, 32'h0, 1'b0);
      chk(wr_en_o == (k != 2), "R11", "chained compare write",
          {31'd0, wr_en_o}, {31'd0, k != 2});
    end

    // Never code (R10) and idle (R13)
    issue(1, 4'hD, 4'hF, 1, 32'h0, 32'h1234, 1'b1);
    issue(0, 4'h4, 4'hE, 1, 32'h1, 32'h1, 1'b0);

    // Random mix (R8 and all classes)
    for (int i = 0; i < 4000; i++) begin
      issue($urandom_range(0, 9) != 0, 4'($urandom), 4'($urandom),
            1'($urandom), pick(), pick(), 1'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule